// File: doc/BRIEF.md
# Pulse-Interval Block Demodulator

This block turns a stream of 8-bit envelope samples from a low-frequency reader front end into 128-bit data blocks. It watches for peaks and troughs in alternation. A peak is accepted only when the envelope has begun to fall and is still above an upper threshold. A trough is accepted only when the envelope has begun to rise and is still below a lower threshold. The block measures the number of valid samples between consecutive accepted extrema. Each interval is classed as short, medium or long, relative to a nominal bit period of 64 samples, with a tolerance of 8 samples.

A long interval carries a one, and a pair of medium intervals carries a zero. A short interval that is followed at once by another short or medium interval is a block separator. At a separator, the bits gathered so far are delivered, but only when there are exactly 128 of them. The block then discards a fixed run of samples that depends on the separator type. Unclassifiable intervals are counted, and decoding gives up after too many of them. Decoding also ends once four blocks have been delivered. A pulse on `start` arms the block and clears all of its state.

Top module: `pid_block_demod`

## Requirements
- R1: After reset, `blk_vld`, `err` and `done` are 0. Samples that arrive before the first `start` pulse change nothing that later decoding depends on.
- R2: A peak is detected on the first sample that is lower than its predecessor while still above 192. A trough is detected on the first sample that is higher than its predecessor while still below 64. Peaks and troughs are sought strictly in turn. The search direction after `start` comes from the first two samples: rising means a peak is sought first. A peak that falls to exactly 192, a trough that rises to exactly 64, and an extremum of the wrong polarity are all ignored.
- R3: An interval is the count of valid samples from one detection to the next. The classes are short (9 to 23), medium (25 to 39) and long (57 to 71). Every other length is unmatched. The first detection after `start`, or after a skip, only sets the reference point.
- R4: A long interval appends a 1. Two medium intervals append a 0. A long interval between the two halves does not cancel the pending half.
- R5: A short or medium interval that directly follows a short interval is a separator. Any other interval between the two breaks the pairing. After a short-short separator, the next 350 valid samples are discarded. After a short-medium separator, the next 334 are discarded. The last discarded sample becomes the new reference. The next extremum sought is a peak if that sample did not fall from its predecessor, and a trough otherwise.
- R6: At a separator, `blk_vld` pulses for one cycle if exactly 128 bits were gathered. `blk_data` bit k is the k-th bit received, so byte j is `blk_data[8j+7:8j]` with its earliest bit in the LSB. Blocks of any other bit count are dropped.
- R7: Every separator clears the bit count, the pending half-bit and the pairing state.
- R8: Each unmatched interval increments an error count. The eleventh one sets `err` and `done`, which stay set until `start`. Ten unmatched intervals leave decoding running.
- R9: `blk_num` numbers the delivered blocks from 0. After the fourth block, `done` rises in the same cycle and no further block is delivered.
- R10: Cycles with `smp_vld` low are not counted in any interval or skip, whatever `smp` holds.
- R11: A `start` pulse clears `done`, `err`, the block and error counts, and all detection state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms decoding and clears all state |
| smp_vld | input | 1 | Marks `smp` as a valid sample this cycle |
| smp | input | 8 | Envelope sample, unsigned |
| blk_vld | output | 1 | One-cycle strobe for a delivered block |
| blk_data | output | 128 | Delivered block, first bit in bit 0 |
| blk_num | output | 2 | Index of the delivered block |
| err | output | 1 | Decoding aborted on too many unmatched intervals |
| done | output | 1 | Decoding finished, by abort or after four blocks |

## Verification
The hardest case to reach from the ports is the exact length of the post-separator skip. An error of one sample shifts only the first interval of the following block. That shift goes unseen unless the interval sits at a tolerance edge. The stimulus therefore opens each block with an interval of 25, 39, 57 or 71 samples. A skip that is off by one then turns that interval into an unmatched one, loses a bit, and drops the whole block. Decoy extrema that stop exactly at a threshold, extrema of the wrong polarity, a half-bit left pending before a separator, and invalid cycles carrying extreme sample values are also placed in the stream. Each of these has an effect only when the matching rule is broken.

// File: rtl/pid_pkg.sv
package pid_pkg;

   typedef enum logic [2:0] {
      IV_NONE  = 3'd0,
      IV_SHORT = 3'd1,
      IV_MED   = 3'd2,
      IV_LONG  = 3'd3,
      IV_BAD   = 3'd4
   } iv_class_e;

   typedef enum logic {
      SEEK_MIN = 1'b0,
      SEEK_MAX = 1'b1
   } seek_e;

endpackage

// File: rtl/pid_extremum.sv
module pid_extremum
   import pid_pkg::*;
#(
   parameter int SMP_W = 8,
   parameter int HI_TH = 192,
   parameter int LO_TH = 64,
   parameter int CNT_W = 9,
   parameter int SKP_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp,
   input  logic             skip_ld,
   input  logic [SKP_W-1:0] skip_len,
   output logic             ev,
   output logic [CNT_W-1:0] ev_len
);

   localparam logic [SMP_W-1:0] HI_V = SMP_W'(HI_TH);
   localparam logic [SMP_W-1:0] LO_V = SMP_W'(LO_TH);

   logic [SMP_W-1:0] prev;
   logic             have_prev;
   logic             have_dir;
   logic             have_ref;
   seek_e            seek;
   logic [CNT_W-1:0] gap;
   logic [SKP_W-1:0] skip_cnt;

   logic             take;
   logic             skipping;
   logic             is_max;
   logic             is_min;
   logic             hit;
   logic [CNT_W-1:0] gap_inc;

   always_comb begin
      take     = run && smp_vld;
      skipping = (skip_cnt != '0);
      is_max   = (seek == SEEK_MAX) && (prev > smp) && (smp > HI_V);
      is_min   = (seek == SEEK_MIN) && (prev < smp) && (smp < LO_V);
      hit      = take && have_dir && !skipping && (is_max || is_min);
      gap_inc  = (gap == '1) ? gap : gap + 1'b1;
      ev       = hit && have_ref;
      ev_len   = gap_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev      <= '0;
         have_prev <= 1'b0;
         have_dir  <= 1'b0;
         have_ref  <= 1'b0;
         seek      <= SEEK_MAX;
         gap       <= '0;
         skip_cnt  <= '0;
      end else if (restart) begin
         have_prev <= 1'b0;
         have_dir  <= 1'b0;
         have_ref  <= 1'b0;
         seek      <= SEEK_MAX;
         gap       <= '0;
         skip_cnt  <= '0;
      end else if (take) begin
         prev      <= smp;
         have_prev <= 1'b1;
         if (!have_prev) begin
            gap <= '0;
         end else if (!have_dir) begin
            have_dir <= 1'b1;
            seek     <= (smp > prev) ? SEEK_MAX : SEEK_MIN;
         end else if (skipping) begin
            skip_cnt <= skip_cnt - 1'b1;
            if (skip_cnt == SKP_W'(1)) begin
               gap  <= '0;
               seek <= (prev > smp) ? SEEK_MIN : SEEK_MAX;
            end
         end else if (hit) begin
            have_ref <= 1'b1;
            gap      <= '0;
            seek     <= (seek == SEEK_MAX) ? SEEK_MIN : SEEK_MAX;
            if (skip_ld) begin
               skip_cnt <= skip_len;
            end
         end else begin
            gap <= gap_inc;
         end
      end
   end

endmodule

// File: rtl/pid_classify.sv
module pid_classify
   import pid_pkg::*;
#(
   parameter int PERIOD = 64,
   parameter int TOL    = 8,
   parameter int CNT_W  = 9
) (
   input  logic             ev,
   input  logic [CNT_W-1:0] len,
   output iv_class_e        cls
);

   // window 0 = quarter period, 1 = half period, 2 = full period
   logic [2:0] win;

   for (genvar g = 0; g < 3; g++) begin : g_win
      localparam int CTR = PERIOD >> (2 - g);
      assign win[g] = (int'(len) > (CTR - TOL)) && (int'(len) < (CTR + TOL));
   end

   always_comb begin
      if (!ev)         cls = IV_NONE;
      else if (win[0]) cls = IV_SHORT;
      else if (win[1]) cls = IV_MED;
      else if (win[2]) cls = IV_LONG;
      else             cls = IV_BAD;
   end

endmodule

// File: rtl/pid_assembler.sv
module pid_assembler
   import pid_pkg::*;
#(
   parameter int BLK_BITS = 128,
   parameter int N_BLOCKS = 4,
   parameter int MAX_ERR  = 10,
   parameter int SKIP_SS  = 351,
   parameter int SKIP_SM  = 335,
   parameter int SKP_W    = 9,
   parameter int NB_W     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                ev,
   input  iv_class_e           cls,
   output logic                run,
   output logic                skip_ld,
   output logic [SKP_W-1:0]    skip_len,
   output logic                blk_vld,
   output logic [BLK_BITS-1:0] blk_data,
   output logic [NB_W-1:0]     blk_num,
   output logic                err,
   output logic                done
);

   localparam int BC_W  = $clog2(BLK_BITS + 2);
   localparam int IDX_W = $clog2(BLK_BITS);
   localparam int NBK_W = $clog2(N_BLOCKS + 1);
   localparam int EC_W  = $clog2(MAX_ERR + 1);

   localparam logic [BC_W-1:0]  FULL     = BC_W'(BLK_BITS);
   localparam logic [BC_W-1:0]  OVER     = BC_W'(BLK_BITS + 1);
   localparam logic [NBK_W-1:0] LAST_BLK = NBK_W'(N_BLOCKS - 1);
   localparam logic [EC_W-1:0]  ERR_LIM  = EC_W'(MAX_ERR);

   logic                active;
   logic                prev_short;
   logic                half;
   logic [BC_W-1:0]     bcnt;
   logic [BLK_BITS-1:0] bits;
   logic [NBK_W-1:0]    nblk;
   logic [EC_W-1:0]     ecnt;

   logic                marker;
   logic                want_push;
   logic                push_bit;

   always_comb begin
      run       = active;
      marker    = ev && prev_short && ((cls == IV_SHORT) || (cls == IV_MED));
      skip_ld   = marker;
      skip_len  = (cls == IV_SHORT) ? SKP_W'(SKIP_SS - 1) : SKP_W'(SKIP_SM - 1);
      want_push = ev && !marker && ((cls == IV_LONG) || ((cls == IV_MED) && half));
      push_bit  = (cls == IV_LONG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         prev_short <= 1'b0;
         half       <= 1'b0;
         bcnt       <= '0;
         bits       <= '0;
         nblk       <= '0;
         ecnt       <= '0;
         blk_vld    <= 1'b0;
         blk_data   <= '0;
         blk_num    <= '0;
         err        <= 1'b0;
         done       <= 1'b0;
      end else begin
         blk_vld <= 1'b0;
         if (restart) begin
            active     <= 1'b1;
            prev_short <= 1'b0;
            half       <= 1'b0;
            bcnt       <= '0;
            nblk       <= '0;
            ecnt       <= '0;
            err        <= 1'b0;
            done       <= 1'b0;
         end else if (ev && active) begin
            if (marker) begin
               if (bcnt == FULL) begin
                  blk_vld  <= 1'b1;
                  blk_data <= bits;
                  blk_num  <= NB_W'(nblk);
                  nblk     <= nblk + 1'b1;
                  if (nblk == LAST_BLK) begin
                     done   <= 1'b1;
                     active <= 1'b0;
                  end
               end
               bcnt       <= '0;
               half       <= 1'b0;
               prev_short <= 1'b0;
            end else begin
               unique case (cls)
                  IV_SHORT: prev_short <= 1'b1;
                  IV_MED: begin
                     prev_short <= 1'b0;
                     half       <= !half;
                  end
                  IV_LONG: prev_short <= 1'b0;
                  IV_BAD: begin
                     prev_short <= 1'b0;
                     ecnt       <= ecnt + 1'b1;
                     if (ecnt == ERR_LIM) begin
                        err    <= 1'b1;
                        done   <= 1'b1;
                        active <= 1'b0;
                     end
                  end
                  default: prev_short <= prev_short;
               endcase
               if (want_push) begin
                  if (bcnt < FULL) begin
                     bits[bcnt[IDX_W-1:0]] <= push_bit;
                  end
                  if (bcnt != OVER) begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/pid_block_demod.sv
module pid_block_demod
   import pid_pkg::*;
#(
   parameter int SMP_W    = 8,
   parameter int PERIOD   = 64,
   parameter int TOL      = PERIOD / 8,
   parameter int HI_TH    = 192,
   parameter int LO_TH    = 64,
   parameter int BLK_BITS = 128,
   parameter int N_BLOCKS = 4,
   parameter int MAX_ERR  = 10,
   parameter int SKIP_SS  = 351,
   parameter int SKIP_SM  = 335,
   localparam int NB_W    = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                smp_vld,
   input  logic [SMP_W-1:0]    smp,
   output logic                blk_vld,
   output logic [BLK_BITS-1:0] blk_data,
   output logic [NB_W-1:0]     blk_num,
   output logic                err,
   output logic                done
);

   localparam int CNT_W    = $clog2(2 * PERIOD) + 1;
   localparam int SKIP_MAX = (SKIP_SS > SKIP_SM) ? SKIP_SS : SKIP_SM;
   localparam int SKP_W    = $clog2(SKIP_MAX) + 1;

   if (BLK_BITS % 8 != 0 || BLK_BITS < 8) begin : g_chk_bits
      $error("BLK_BITS must be a positive multiple of 8");
   end
   if (TOL < 1 || TOL > PERIOD / 8) begin : g_chk_tol
      $error("TOL must lie in 1..PERIOD/8 so that the windows stay disjoint");
   end
   if (SKIP_SS < 2 || SKIP_SM < 2) begin : g_chk_skip
      $error("skip lengths must be at least 2");
   end
   if (HI_TH <= LO_TH || HI_TH >= (1 << SMP_W)) begin : g_chk_th
      $error("thresholds must satisfy LO_TH < HI_TH < 2**SMP_W");
   end
   if (N_BLOCKS < 1 || MAX_ERR < 1) begin : g_chk_cnt
      $error("N_BLOCKS and MAX_ERR must be positive");
   end

   logic             run;
   logic             iv_ev;
   logic [CNT_W-1:0] iv_len;
   iv_class_e        iv_cls;
   logic             skip_ld;
   logic [SKP_W-1:0] skip_len;

   pid_extremum #(
      .SMP_W (SMP_W),
      .HI_TH (HI_TH),
      .LO_TH (LO_TH),
      .CNT_W (CNT_W),
      .SKP_W (SKP_W)
   ) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (start),
      .run      (run),
      .smp_vld  (smp_vld),
      .smp      (smp),
      .skip_ld  (skip_ld),
      .skip_len (skip_len),
      .ev       (iv_ev),
      .ev_len   (iv_len)
   );

   pid_classify #(
      .PERIOD (PERIOD),
      .TOL    (TOL),
      .CNT_W  (CNT_W)
   ) u_cls (
      .ev  (iv_ev),
      .len (iv_len),
      .cls (iv_cls)
   );

   pid_assembler #(
      .BLK_BITS (BLK_BITS),
      .N_BLOCKS (N_BLOCKS),
      .MAX_ERR  (MAX_ERR),
      .SKIP_SS  (SKIP_SS),
      .SKIP_SM  (SKIP_SM),
      .SKP_W    (SKP_W),
      .NB_W     (NB_W)
   ) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (start),
      .ev       (iv_ev),
      .cls      (iv_cls),
      .run      (run),
      .skip_ld  (skip_ld),
      .skip_len (skip_len),
      .blk_vld  (blk_vld),
      .blk_data (blk_data),
      .blk_num  (blk_num),
      .err      (err),
      .done     (done)
   );

endmodule

// File: rtl/pid_block_demod_chk.sv
module pid_block_demod_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic blk_vld,
   input logic err,
   input logic done,
   input logic ev,
   input logic skip_ld
);

   // R11
   p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && !err));

   // R9
   p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R8
   p_err_sets_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R8
   p_err_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);

   // R6
   p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      blk_vld |=> !blk_vld);

   // R9
   p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !blk_vld);

   // R5
   p_marker_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      skip_ld |-> ev);

endmodule

bind pid_block_demod pid_block_demod_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .blk_vld (blk_vld),
   .err     (err),
   .done    (done),
   .ev      (iv_ev),
   .skip_ld (skip_ld)
);

// File: tb/pid_block_demod_bench.sv
module pid_block_demod_bench;

   localparam int CLK_P   = 10;
   localparam int SKIP_SS = 351;
   localparam int SKIP_SM = 335;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         smp_vld = 1'b0;
   logic [7:0]   smp = 8'd128;
   logic         blk_vld;
   logic [127:0] blk_data;
   logic [1:0]   blk_num;
   logic         err;
   logic         done;

   int n_chk = 0;
   int n_fail = 0;
   bit nxt_max = 1'b1;
   bit gap_mode = 1'b0;
   int gcount = 0;
   int got = 0;
   logic [127:0] got_data [8];
   int           got_num  [8];

   always #(CLK_P / 2) clk = ~clk;

   pid_block_demod u_pid_block_demod (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .smp_vld  (smp_vld),
      .smp      (smp),
      .blk_vld  (blk_vld),
      .blk_data (blk_data),
      .blk_num  (blk_num),
      .err      (err),
      .done     (done)
   );

   always @(posedge clk) begin
      #1;
      if (blk_vld) begin
         if (got < 8) begin
            got_data[got] = blk_data;
            got_num[got]  = int'(blk_num);
         end
         got++;
      end
   end

   function automatic bit pat(int k, int i);
      case (k % 4)
         0:       return (i % 3) == 0;
         1:       return (i % 2) == 1;
         2:       return (((i * 37 + 11) >> 2) & 1) == 1;
         default: return (i % 3) != 0;
      endcase
   endfunction

   function automatic logic [127:0] exp_vec(int k);
      logic [127:0] v;
      for (int i = 0; i < 128; i++) v[i] = pat(k, i);
      return v;
   endfunction

   task automatic chk(string rq, string what, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic put(int v);
      if (gap_mode && (gcount % 3) == 2) begin
         @(negedge clk);
         smp_vld = 1'b0;
         smp = ((gcount % 2) == 1) ? 8'd0 : 8'd255;
      end
      gcount++;
      @(negedge clk);
      smp_vld = 1'b1;
      smp = 8'(v);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         smp_vld = 1'b0;
         smp = 8'd128;
      end
   endtask

   task automatic flat(int n);
      repeat (n) put(128);
   endtask

   task automatic ext();
      if (nxt_max) begin
         put(250);
         put(220);
      end else begin
         put(5);
         put(40);
      end
      nxt_max = !nxt_max;
   endtask

   task automatic ivl(int len);
      flat(len - 2);
      ext();
   endtask

   // R2: a threshold-edge decoy and a wrong-polarity decoy inside one interval
   task automatic ivl_decoy(int len);
      flat(6);
      if (nxt_max) begin
         put(250); put(192);
         flat(6);
         put(5); put(40);
      end else begin
         put(5); put(64);
         flat(6);
         put(250); put(220);
      end
      flat(len - 18);
      ext();
   endtask

   task automatic send_block(int k, int nb, bit pend, bit decoys);
      for (int i = 0; i < nb; i++) begin
         int len;
         if (pat(k, i)) begin
            if (i == 0) len = (k % 2 == 1) ? 71 : 57;
            else        len = (i % 3 == 0) ? 57 : ((i % 3 == 1) ? 64 : 71);
            if (decoys && (i % 5 == 0)) ivl_decoy(len);
            else ivl(len);
         end else begin
            if (i == 0) len = (k % 2 == 1) ? 39 : 25;
            else        len = (i % 3 == 0) ? 25 : ((i % 3 == 1) ? 32 : 39);
            ivl(len);
            ivl(32);
         end
      end
      if (pend) ivl(32);
      ivl((k % 2 == 1) ? 9 : 23);
      if (k % 2 == 1) begin
         ivl((k % 4 == 1) ? 25 : 39);
         flat(SKIP_SM - 1);
      end else begin
         ivl(16);
         flat(SKIP_SS - 1);
      end
      nxt_max = 1'b1;
   endtask

   task automatic prelude();
      put(100);
      put(128);
      nxt_max = 1'b1;
      flat(5);
      ext();
   endtask

   task automatic do_start();
      @(negedge clk);
      smp_vld = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #2;
      got = 0;
      gcount = 0;
      prelude();
   endtask

   initial begin
      #(CLK_P * 180000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "blk_vld after reset", 128'(blk_vld), 128'd0);
      chk("R1", "err after reset", 128'(err), 128'd0);
      chk("R1", "done after reset", 128'(done), 128'd0);

      // R1: pre-start samples would add three bits to the first block
      prelude();
      ivl(64); ivl(64); ivl(64);
      idle(5);

      // main run: four blocks, both separator kinds, decoys, pending half
      do_start();
      send_block(0, 128, 1'b0, 1'b0);
      send_block(1, 128, 1'b1, 1'b1);   // R7: pending half before separator
      send_block(2, 128, 1'b0, 1'b1);   // R2: decoys
      send_block(3, 128, 1'b0, 1'b0);
      idle(5);
      chk("R9", "block count after four blocks", 128'(got), 128'd4);
      for (int k = 0; k < 4; k++) begin
         // R4 R5 R6 R3: data at tolerance edges and after exact skips
         chk("R6", $sformatf("block %0d data", k), got_data[k], exp_vec(k));
         chk("R9", $sformatf("block %0d number", k), 128'(got_num[k]), 128'(k));
      end
      chk("R9", "done after fourth block", 128'(done), 128'd1);
      send_block(0, 128, 1'b0, 1'b0);
      idle(5);
      chk("R9", "no block after done", 128'(got), 128'd4);
      chk("R9", "done holds", 128'(done), 128'd1);

      // R10 R11 R6: restart, invalid gaps, wrong bit counts dropped
      do_start();
      chk("R11", "done cleared by start", 128'(done), 128'd0);
      gap_mode = 1'b1;
      send_block(1, 5, 1'b0, 1'b0);
      send_block(2, 129, 1'b0, 1'b0);
      send_block(1, 128, 1'b0, 1'b0);
      gap_mode = 1'b0;
      idle(5);
      chk("R6", "only the 128-bit block kept", 128'(got), 128'd1);
      chk("R10", "data with invalid gaps", got_data[0], exp_vec(1));
      chk("R11", "numbering restarts", 128'(got_num[0]), 128'd0);
      chk("R10", "not done", 128'(done), 128'd0);

      // R8 R3: unmatched lengths just outside every window
      do_start();
      ivl(8); ivl(24); ivl(40); ivl(56); ivl(72);
      ivl(24); ivl(8); ivl(100); ivl(200); ivl(300);
      idle(3);
      chk("R8", "err after ten unmatched", 128'(err), 128'd0);
      chk("R8", "done after ten unmatched", 128'(done), 128'd0);
      ivl(48);
      idle(3);
      chk("R8", "err after eleventh unmatched", 128'(err), 128'd1);
      chk("R8", "done after eleventh unmatched", 128'(done), 128'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule